// File: doc/BRIEF.md
# Radix-4 Inter-Stage Index Transpose Buffer

This block sits between two passes of a radix-4 FFT datapath. Each butterfly pass produces four results whose indices lie a quarter-frame apart. The block takes these as one four-sample word and steers each word into one of four parallel storage banks. The bank is chosen by a 2-bit group code taken from a write counter. Once a whole frame of N samples is held, the block plays the frame back one slot position at a time, taking one sample from every bank. Each output word therefore carries four consecutive indices. This performs the stride-to-natural transpose without any address arithmetic on the samples themselves.

Both data sides use valid/ready handshakes. A word moves on a side only in a cycle where valid and ready are both high. The block alternates between two phases. While collecting, `in_ready` is high and `out_valid` is low. While playing back, `out_valid` is high and `in_ready` is low. This means a producer is back-pressured for the whole playback. A consumer may stall playback at any beat by holding `out_ready` low. The frame size `N_PTS` defaults to 16 and may be set to 64. Sample width is set by `SAMP_W`.

Top module: `stage_transpose_buf`

## Requirements
- R1: After reset, and again after a reset asserted mid-frame, `in_ready` is 1 and `out_valid` is 0, and the next frame is collected from its first word.
- R2: Input word w (counting accepted words from 0) carries, in lane j (bits `j*SAMP_W +: SAMP_W`), the sample of index w + j*N_PTS/4. It is stored in bank (w mod 4), selected by a 2-bit code: 00 for bank 0 through 11 for bank 3. Exactly one bank is written per accepted word.
- R3: `out_valid` stays 0 until N_PTS/4 words have been accepted. It rises in the cycle right after the last accepted word.
- R4: Output beat r (counting accepted beats from 0) carries, in lane b, the sample of index 4r + b.
- R5: `out_ready` while `out_valid` is 0 has no effect. `in_valid` while `in_ready` is 0 has no effect, and the held frame is unchanged.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values.
- R7: After N_PTS/4 accepted output beats, `out_valid` falls and `in_ready` rises in the next cycle. A following frame is then collected and played back correctly.
- R8: Idle cycles between input words do not change which bank or slot the next word goes to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block is collecting and accepts a word |
| in_data | input | 4*SAMP_W | Four butterfly results, lane j = index w + j*N_PTS/4 |
| out_valid | output | 1 | Playback word available |
| out_ready | input | 1 | Consumer takes the playback word (read request) |
| out_data | output | 4*SAMP_W | Four consecutive-index samples, lane b = index 4r + b |

## Verification
Two functions can fall in the same cycle. The first case is the final input word of a frame arriving while the consumer already holds `out_ready` high. The bench drives exactly that and then checks three things: `out_valid` rises one cycle later, no beat is lost, and the first beat still carries indices 0 to 3. The second case is the last playback beat being taken while a producer offers a new word. The bench offers a junk word in that cycle and checks that it is dropped: `in_ready` returns only in the next cycle, and the following frame plays back correctly from bank 0.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    GRP_B0 = 2'b00,
    GRP_B1 = 2'b01,
    GRP_B2 = 2'b10,
    GRP_B3 = 2'b11
  } grp_code_e;
endpackage

// File: rtl/xpose_wr_seq.sv
module xpose_wr_seq #(
  parameter int unsigned N_PTS = 16,
  localparam int unsigned DEPTH = N_PTS / 4,
  localparam int unsigned SW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  output xpose_pkg::grp_code_e  grp,
  output logic [SW-1:0]         base,
  output logic                  last
);
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (accept) cnt <= (cnt == SW'(DEPTH - 1)) ? '0 : cnt + 1'b1;
  end

  assign grp  = xpose_pkg::grp_code_e'(cnt[1:0]);
  assign base = SW'(cnt >> 2);
  assign last = (cnt == SW'(DEPTH - 1));

  // R8: idle cycles leave the write position untouched
  p_wr_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cnt));
endmodule

// File: rtl/xpose_rd_seq.sv
module xpose_rd_seq #(
  parameter int unsigned N_PTS = 16,
  localparam int unsigned DEPTH = N_PTS / 4,
  localparam int unsigned SW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  output logic [SW-1:0] slot,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n) slot <= '0;
    else if (accept) slot <= (slot == SW'(DEPTH - 1)) ? '0 : slot + 1'b1;
  end

  assign last = (slot == SW'(DEPTH - 1));

  // R6: a stalled beat keeps its slot
  p_rd_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(slot));
endmodule

// File: rtl/xpose_bank.sv
module xpose_bank #(
  parameter int unsigned SAMP_W = 16,
  parameter int unsigned N_PTS = 16,
  localparam int unsigned LANES = xpose_pkg::LANES,
  localparam int unsigned DEPTH = N_PTS / 4,
  localparam int unsigned SW = $clog2(DEPTH),
  localparam int unsigned STEP = N_PTS / 16
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [SW-1:0]                base,
  input  logic [LANES-1:0][SAMP_W-1:0] din,
  input  logic [SW-1:0]                rd_slot,
  output logic [SAMP_W-1:0]            dout
);
  logic [SAMP_W-1:0] mem [DEPTH];

  // lane j of the word holds index (base*4 + bank) + j*N/4 -> slot base + j*STEP
  always_ff @(posedge clk) begin
    if (we) begin
      for (int j = 0; j < LANES; j++) begin
        mem[base + SW'(j * STEP)] <= din[j];
      end
    end
  end

  assign dout = mem[rd_slot];
endmodule

// File: rtl/stage_transpose_buf.sv
module stage_transpose_buf #(
  parameter int unsigned SAMP_W = 16,
  parameter int unsigned N_PTS = 16,
  localparam int unsigned LANES = xpose_pkg::LANES,
  localparam int unsigned DEPTH = N_PTS / 4,
  localparam int unsigned SW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*SAMP_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*SAMP_W-1:0] out_data
);
  logic                         held;
  logic                         wr_acc, rd_acc;
  logic                         wr_last, rd_last;
  xpose_pkg::grp_code_e         grp;
  logic [SW-1:0]                wr_base, rd_slot;
  logic [LANES-1:0][SAMP_W-1:0] in_lanes, out_lanes;
  logic [LANES-1:0]             bank_we;

  assign in_ready  = !held;
  assign out_valid = held;
  assign wr_acc    = in_valid && !held;
  assign rd_acc    = out_ready && held;
  assign in_lanes  = in_data;
  assign out_data  = out_lanes;

  always_ff @(posedge clk) begin
    if (!rst_n) held <= 1'b0;
    else if (wr_acc && wr_last) held <= 1'b1;
    else if (rd_acc && rd_last) held <= 1'b0;
  end

  xpose_wr_seq #(.N_PTS(N_PTS)) u_wr (
    .clk(clk), .rst_n(rst_n), .accept(wr_acc),
    .grp(grp), .base(wr_base), .last(wr_last)
  );

  xpose_rd_seq #(.N_PTS(N_PTS)) u_rd (
    .clk(clk), .rst_n(rst_n), .accept(rd_acc),
    .slot(rd_slot), .last(rd_last)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    assign bank_we[b] = wr_acc && (grp == xpose_pkg::grp_code_e'(b));
    xpose_bank #(.SAMP_W(SAMP_W), .N_PTS(N_PTS)) u_bank (
      .clk(clk), .we(bank_we[b]), .base(wr_base), .din(in_lanes),
      .rd_slot(rd_slot), .dout(out_lanes[b])
    );
  end

  // R2: a single bank takes each word
  p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we) && (wr_acc == (|bank_we)));

  // R3: playback opens right after the last word
  p_fill_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && wr_last) |=> out_valid);

  // R3: no early playback
  p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !(in_valid && in_ready && wr_last)) |=> !out_valid);

  // R6: stalled output holds
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: collection reopens after the last beat
  p_drain_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && rd_last) |=> (in_ready && !out_valid));
endmodule

// File: tb/stage_transpose_buf_bench.sv
module stage_transpose_buf_bench;
  localparam int unsigned W = 16;
  localparam int unsigned N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [4*W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [4*W-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stage_transpose_buf #(.SAMP_W(W), .N_PTS(N)) u_stage_transpose_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // stimulus / expected vectors: sample value 0x0A00 | index
  localparam logic [63:0] VEC_IN [4] = '{
    {16'h0A0C, 16'h0A08, 16'h0A04, 16'h0A00},
    {16'h0A0D, 16'h0A09, 16'h0A05, 16'h0A01},
    {16'h0A0E, 16'h0A0A, 16'h0A06, 16'h0A02},
    {16'h0A0F, 16'h0A0B, 16'h0A07, 16'h0A03}
  };
  localparam logic [63:0] VEC_OUT [4] = '{
    {16'h0A03, 16'h0A02, 16'h0A01, 16'h0A00},
    {16'h0A07, 16'h0A06, 16'h0A05, 16'h0A04},
    {16'h0A0B, 16'h0A0A, 16'h0A09, 16'h0A08},
    {16'h0A0F, 16'h0A0E, 16'h0A0D, 16'h0A0C}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] in_word(input logic [15:0] tag, input int w);
    logic [63:0] v;
    for (int j = 0; j < 4; j++) v[j*16 +: 16] = tag | 16'(w + j*4);
    return v;
  endfunction

  function automatic logic [63:0] out_word(input logic [15:0] tag, input int r);
    logic [63:0] v;
    for (int b = 0; b < 4; b++) v[b*16 +: 16] = tag | 16'(4*r + b);
    return v;
  endfunction

  task automatic put(input logic [63:0] word, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    chk("R3 no early valid", 64'(out_valid), 64'd0);
    in_valid = 1'b1;
    in_data = word;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic get(input logic [63:0] exp, input string req);
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk(req, out_data, exp);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset in_ready", 64'(in_ready), 64'd1);
    chk("R1 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;

    // table frame; consumer requests early (R5, same-cycle with last write)
    out_ready = 1'b1;
    for (int r = 0; r < 4; r++) put(VEC_IN[r], 0);
    out_ready = 1'b0;
    chk("R3 valid after last write", 64'(out_valid), 64'd1);
    chk("R3 in_ready low when full", 64'(in_ready), 64'd0);

    // stall with junk offered (R5, R6)
    begin
      logic [63:0] snap;
      snap = out_data;
      in_valid = 1'b1;
      in_data = 64'hDEAD_BEEF_DEAD_BEEF;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      chk("R6 stalled data held", out_data, snap);
      chk("R6 stalled valid held", 64'(out_valid), 64'd1);
    end

    for (int r = 0; r < 4; r++) get(VEC_OUT[r], "R4 R5 table beat");
    chk("R7 valid falls", 64'(out_valid), 64'd0);
    chk("R7 in_ready back", 64'(in_ready), 64'd1);

    // frame with gaps (R8), junk offered on final beat (R7)
    for (int w = 0; w < 4; w++) put(in_word(16'hB000, w), w);
    for (int r = 0; r < 3; r++) get(out_word(16'hB000, r), "R8 gapped beat");
    in_valid = 1'b1;
    in_data = 64'hFFFF_FFFF_FFFF_FFFF;
    chk("R5 in_ready low at last beat", 64'(in_ready), 64'd0);
    get(out_word(16'hB000, 3), "R8 gapped beat");
    in_valid = 1'b0;
    chk("R7 in_ready after drain", 64'(in_ready), 64'd1);
    chk("R7 out_valid after drain", 64'(out_valid), 64'd0);

    // next frame after the overlapping cycle (R2, R7)
    for (int w = 0; w < 4; w++) put(in_word(16'hC000, w), 0);
    for (int r = 0; r < 4; r++) get(out_word(16'hC000, r), "R2 R7 next frame beat");

    // reset mid-fill (R1)
    put(in_word(16'h5000, 0), 0);
    put(in_word(16'h5000, 1), 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 mid reset in_ready", 64'(in_ready), 64'd1);
    chk("R1 mid reset out_valid", 64'(out_valid), 64'd0);
    for (int w = 0; w < 4; w++) put(in_word(16'h7000, w), 0);
    for (int r = 0; r < 4; r++) get(out_word(16'h7000, r), "R1 R4 after reset beat");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule